// File: doc/BRIEF.md
# Region-Based Next-Hop Selector

This block picks the outgoing neighbor for a packet at one node of an irregular on-chip packet network. A destination coordinate pair taken from the packet header enters on a valid/ready stream. One cycle later the block returns, on a second valid/ready stream, the neighbor port index and the address of that neighbor, which the caller writes into the header as the next hop.

The decision has two stages. First, the destination is compared against every enabled entry of the neighbor table. If it matches, the packet is one hop from home: the lowest matching port is chosen and the destination itself is the next hop. Otherwise, the destination is tested against a table of rectangular regions. Each region is owned by one neighbor port. A fixed priority resolves overlapping rectangles in favour of the lowest region index, and the owner's stored address becomes the next hop. If nothing matches, an error flag is raised. Both tables start empty after reset and are filled through a simple write port.

Back-pressure: a result is held unchanged while `out_valid` is high and `out_ready` is low. During that time `in_ready` is low, so no new destination is accepted. A destination is taken on a rising edge only when `in_valid` and `in_ready` are both high.

Top module: `nexthop_router`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and both tables are empty, so every lookup reports an error.
- R2: A destination equal to the address of an enabled neighbor gives `out_direct`=1, `out_err`=0, `out_port` equal to the lowest such neighbor index, and `out_next` equal to the destination. The region table plays no part.
- R3: Region bounds are inclusive: a region hits only when xmin <= dx <= xmax and ymin <= dy <= ymax, with both sides of each bound included.
- R4: When several enabled regions contain the destination, the one with the lowest index wins.
- R5: On a region hit, `out_port` is the owner port of the winning region and `out_next` is the address stored for that neighbor port, with `out_direct`=0 and `out_err`=0.
- R6: If no neighbor matches and no region hits, then `out_err`=1, `out_port`=0, `out_next`=0 and `out_direct`=0.
- R7: A destination accepted on a rising edge produces `out_valid`=1 with its result right after that edge. Without a new acceptance, `out_valid` falls once the result has been taken.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs hold their values and `in_ready` is 0.
- R9: A table write with `cfg_en`=1 takes effect for lookups accepted after the write edge. An entry written with `cfg_en`=0 never matches and has no effect on any result.
- R10: An address is 10 bits: X in bits [9:5] and Y in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rgn_we | input | 1 | Write the region entry at cfg_idx |
| cfg_nbr_we | input | 1 | Write the neighbor entry at cfg_idx |
| cfg_idx | input | 3 | Table entry index |
| cfg_en | input | 1 | Enable bit stored with the written entry |
| cfg_xmin | input | 5 | Region lower X bound |
| cfg_xmax | input | 5 | Region upper X bound |
| cfg_ymin | input | 5 | Region lower Y bound |
| cfg_ymax | input | 5 | Region upper Y bound |
| cfg_owner | input | 3 | Neighbor port that owns the region |
| cfg_nbr_addr | input | 10 | Neighbor address {X,Y} |
| in_valid | input | 1 | Destination valid |
| in_ready | output | 1 | Destination accepted when high with in_valid |
| in_dx | input | 5 | Destination X |
| in_dy | input | 5 | Destination Y |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_port | output | 3 | Chosen neighbor port |
| out_next | output | 10 | Next-hop address {X,Y} |
| out_direct | output | 1 | Destination is a direct neighbor |
| out_err | output | 1 | No route found |

## Verification
The destinations in the vector walk fall into several groups, and each group separates a different case:
- Exact neighbor addresses confirm that the direct path overrides a region which also covers that point.
- Points on region corners and edges show that the bounds are inclusive rather than off by one.
- Points inside two or three overlapping rectangles expose a wrong priority order.
- A point covered only by a region written with its enable cleared, and a point outside all regions, separate the error path from a disabled entry that is wrongly used.

Rewriting an owner and adding a neighbor between lookups shows when configuration takes effect. Finally, a result is held under a stalled consumer while a second destination waits at the input.

// File: rtl/nhr_pkg.sv
package nhr_pkg;
  localparam int XW = 5;
  localparam int YW = 5;
  localparam int AW = XW + YW;

  typedef struct packed {
    logic          en;
    logic [XW-1:0] xmin;
    logic [XW-1:0] xmax;
    logic [YW-1:0] ymin;
    logic [YW-1:0] ymax;
  } rgn_box_t;
endpackage

// File: rtl/nhr_thresh.sv
// Thermometer of "coordinate >= v" for every v; one comparator per value,
// shared by all regions that use that value as a bound.
module nhr_thresh #(
  parameter int W = 5,
  localparam int NV = 1 << W
) (
  input  logic [W-1:0] d,
  output logic [NV:0]  ge
);
  for (genvar v = 0; v <= NV; v++) begin : g_cmp
    if (v == 0) begin : g_lo
      assign ge[v] = 1'b1;
    end else if (v == NV) begin : g_hi
      assign ge[v] = 1'b0;
    end else begin : g_mid
      assign ge[v] = ({1'b0, d} >= (W+1)'(v));
    end
  end
endmodule

// File: rtl/nhr_region_hits.sv
module nhr_region_hits
  import nhr_pkg::*;
#(
  parameter int NUM_REG = 8
) (
  input  logic [XW-1:0]      dx,
  input  logic [YW-1:0]      dy,
  input  rgn_box_t           box [NUM_REG],
  output logic [NUM_REG-1:0] hit
);
  logic [(1<<XW):0] gx;
  logic [(1<<YW):0] gy;

  nhr_thresh #(.W(XW)) u_tx (.d(dx), .ge(gx));
  nhr_thresh #(.W(YW)) u_ty (.d(dy), .ge(gy));

  for (genvar r = 0; r < NUM_REG; r++) begin : g_rgn
    logic [XW:0] xtop;
    logic [YW:0] ytop;
    assign xtop = {1'b0, box[r].xmax} + 1'b1;
    assign ytop = {1'b0, box[r].ymax} + 1'b1;
    assign hit[r] = box[r].en
                  & gx[box[r].xmin] & ~gx[xtop]
                  & gy[box[r].ymin] & ~gy[ytop];
  end
endmodule

// File: rtl/nhr_prio_pick.sv
// Lowest set request wins.
module nhr_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/nexthop_router.sv
module nexthop_router
  import nhr_pkg::*;
#(
  parameter int NUM_REG = 8,
  parameter int NUM_NBR = 8,
  localparam int RIDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int PORT_W = (NUM_NBR > 1) ? $clog2(NUM_NBR) : 1,
  localparam int IDX_W  = (RIDX_W > PORT_W) ? RIDX_W : PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rgn_we,
  input  logic              cfg_nbr_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [XW-1:0]     cfg_xmin,
  input  logic [XW-1:0]     cfg_xmax,
  input  logic [YW-1:0]     cfg_ymin,
  input  logic [YW-1:0]     cfg_ymax,
  input  logic [PORT_W-1:0] cfg_owner,
  input  logic [AW-1:0]     cfg_nbr_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XW-1:0]     in_dx,
  input  logic [YW-1:0]     in_dy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_port,
  output logic [AW-1:0]     out_next,
  output logic              out_direct,
  output logic              out_err
);
  rgn_box_t             box_q   [NUM_REG];
  logic [PORT_W-1:0]    owner_q [NUM_REG];
  logic [NUM_NBR-1:0]   nbr_en_q;
  logic [AW-1:0]        nbr_addr_q [NUM_NBR];

  logic rgn_sel_ok, nbr_sel_ok;
  assign rgn_sel_ok = ({1'b0, cfg_idx} < (IDX_W+1)'(NUM_REG));
  assign nbr_sel_ok = ({1'b0, cfg_idx} < (IDX_W+1)'(NUM_NBR));

  // Configuration tables
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REG; r++) begin
        box_q[r]   <= '0;
        owner_q[r] <= '0;
      end
      for (int n = 0; n < NUM_NBR; n++) nbr_addr_q[n] <= '0;
      nbr_en_q <= '0;
    end else begin
      if (cfg_rgn_we && rgn_sel_ok) begin
        box_q[cfg_idx[RIDX_W-1:0]]   <= '{en: cfg_en, xmin: cfg_xmin, xmax: cfg_xmax,
                                          ymin: cfg_ymin, ymax: cfg_ymax};
        owner_q[cfg_idx[RIDX_W-1:0]] <= cfg_owner;
      end
      if (cfg_nbr_we && nbr_sel_ok) begin
        nbr_addr_q[cfg_idx[PORT_W-1:0]] <= cfg_nbr_addr;
        nbr_en_q[cfg_idx[PORT_W-1:0]]   <= cfg_en;
      end
    end
  end

  // Direct neighbor check
  logic [AW-1:0]      dest;
  logic [NUM_NBR-1:0] nbr_hit;
  logic               nbr_any;
  logic [PORT_W-1:0]  nbr_idx;

  assign dest = {in_dx, in_dy};

  for (genvar n = 0; n < NUM_NBR; n++) begin : g_nbr
    assign nbr_hit[n] = nbr_en_q[n] && (nbr_addr_q[n] == dest);
  end

  nhr_prio_pick #(.N(NUM_NBR), .IW(PORT_W)) u_nbr_pick (
    .req(nbr_hit), .any(nbr_any), .idx(nbr_idx)
  );

  // Region lookup
  logic [NUM_REG-1:0] rgn_hit;
  logic               rgn_any;
  logic [RIDX_W-1:0]  rgn_idx;
  logic [PORT_W-1:0]  rgn_owner;

  nhr_region_hits #(.NUM_REG(NUM_REG)) u_hits (
    .dx(in_dx), .dy(in_dy), .box(box_q), .hit(rgn_hit)
  );

  nhr_prio_pick #(.N(NUM_REG), .IW(RIDX_W)) u_rgn_pick (
    .req(rgn_hit), .any(rgn_any), .idx(rgn_idx)
  );

  assign rgn_owner = owner_q[rgn_idx];

  // Decision
  logic [PORT_W-1:0] d_port;
  logic [AW-1:0]     d_next;
  logic              d_direct, d_err;

  always_comb begin
    d_port   = '0;
    d_next   = '0;
    d_direct = 1'b0;
    d_err    = 1'b0;
    if (nbr_any) begin
      d_port   = nbr_idx;
      d_next   = dest;
      d_direct = 1'b1;
    end else if (rgn_any) begin
      d_port = rgn_owner;
      d_next = nbr_addr_q[rgn_owner];
    end else begin
      d_err = 1'b1;
    end
  end

  // Output stage with back-pressure
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_port   <= '0;
      out_next   <= '0;
      out_direct <= 1'b0;
      out_err    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port   <= d_port;
        out_next   <= d_next;
        out_direct <= d_direct;
        out_err    <= d_err;
      end
    end
  end
endmodule

// File: rtl/nhr_checker.sv
module nhr_checker #(
  parameter int PORT_W = 3,
  parameter int AW     = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_port,
  input logic [AW-1:0]     out_next,
  input logic              out_direct,
  input logic              out_err
);
  a_r7_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_next)
                                   && $stable(out_direct) && $stable(out_err)));

  a_r8_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_port == '0 && out_next == '0 && !out_direct));

  a_r2_direct_not_err: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_direct) |-> !out_err);
endmodule

bind nexthop_router nhr_checker #(.PORT_W(PORT_W), .AW(nhr_pkg::AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
  .out_next(out_next), .out_direct(out_direct), .out_err(out_err)
);

// File: tb/nexthop_router_test.sv
module nexthop_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_rgn_we = 0, cfg_nbr_we = 0, cfg_en = 0;
  logic [2:0] cfg_idx = 0, cfg_owner = 0;
  logic [4:0] cfg_xmin = 0, cfg_xmax = 0, cfg_ymin = 0, cfg_ymax = 0;
  logic [9:0] cfg_nbr_addr = 0;
  logic       in_valid = 0, out_ready = 1;
  logic [4:0] in_dx = 0, in_dy = 0;
  logic       in_ready, out_valid, out_direct, out_err;
  logic [2:0] out_port;
  logic [9:0] out_next;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nexthop_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_rgn_we(cfg_rgn_we), .cfg_nbr_we(cfg_nbr_we),
    .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_xmin(cfg_xmin), .cfg_xmax(cfg_xmax),
    .cfg_ymin(cfg_ymin), .cfg_ymax(cfg_ymax), .cfg_owner(cfg_owner),
    .cfg_nbr_addr(cfg_nbr_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_dx(in_dx), .in_dy(in_dy), .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .out_next(out_next), .out_direct(out_direct), .out_err(out_err)
  );

  // Reference tables
  logic       r_en [8];
  logic [4:0] r_x0 [8], r_x1 [8], r_y0 [8], r_y1 [8];
  logic [2:0] r_own [8];
  logic       n_en [8];
  logic [9:0] n_adr [8];

  // Vector: {dx, dy, port, next, direct, err}; next = X*32 + Y (R10)
  localparam logic [24:0] VEC [NV] = '{
    {5'd4,  5'd4,  3'd0, 10'd132, 1'b1, 1'b0},  // R2 neighbor 0
    {5'd20, 5'd20, 3'd2, 10'd660, 1'b1, 1'b0},  // R2 neighbor 2 inside region
    {5'd0,  5'd0,  3'd0, 10'd132, 1'b0, 1'b0},  // R3 corner of r0
    {5'd9,  5'd9,  3'd0, 10'd132, 1'b0, 1'b0},  // R3 upper corner of r0
    {5'd10, 5'd0,  3'd1, 10'd644, 1'b0, 1'b0},  // R5 r1
    {5'd31, 5'd15, 3'd1, 10'd644, 1'b0, 1'b0},  // R3 r1 far corner
    {5'd15, 5'd12, 3'd1, 10'd644, 1'b0, 1'b0},  // R4 r1 over r2
    {5'd15, 5'd16, 3'd2, 10'd660, 1'b0, 1'b0},  // R5 r2
    {5'd9,  5'd10, 3'd2, 10'd660, 1'b0, 1'b0},  // R5 only r4
    {5'd7,  5'd10, 3'd3, 10'd148, 1'b0, 1'b0},  // R3 r3 corner
    {5'd0,  5'd31, 3'd3, 10'd148, 1'b0, 1'b0},  // R3 r3 corner
    {5'd31, 5'd20, 3'd0, 10'd0,   1'b0, 1'b1},  // R6 / R9 only disabled r5
    {5'd30, 5'd31, 3'd2, 10'd660, 1'b0, 1'b0},  // R3 r2 corner
    {5'd8,  5'd9,  3'd0, 10'd132, 1'b0, 1'b0}   // R4 r0 over r4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_rgn(input int i, input logic en, input logic [4:0] x0, x1, y0, y1,
                        input logic [2:0] own);
    @(negedge clk);
    cfg_rgn_we = 1; cfg_idx = 3'(i); cfg_en = en;
    cfg_xmin = x0; cfg_xmax = x1; cfg_ymin = y0; cfg_ymax = y1; cfg_owner = own;
    r_en[i] = en; r_x0[i] = x0; r_x1[i] = x1; r_y0[i] = y0; r_y1[i] = y1; r_own[i] = own;
    @(negedge clk);
    cfg_rgn_we = 0;
  endtask

  task automatic wr_nbr(input int i, input logic en, input logic [9:0] a);
    @(negedge clk);
    cfg_nbr_we = 1; cfg_idx = 3'(i); cfg_en = en; cfg_nbr_addr = a;
    n_en[i] = en; n_adr[i] = a;
    @(negedge clk);
    cfg_nbr_we = 0;
  endtask

  // Reference: neighbors first, then regions in priority order
  task automatic ref_look(input logic [4:0] dx, dy, output logic [2:0] p,
                          output logic [9:0] nx, output logic d, e);
    bit found = 0;
    p = 0; nx = 0; d = 0; e = 0;
    for (int n = 0; n < 8; n++)
      if (!found && n_en[n] && n_adr[n] == {dx, dy}) begin
        found = 1; p = 3'(n); nx = {dx, dy}; d = 1;
      end
    for (int r = 0; r < 8; r++)
      if (!found && r_en[r] && dx >= r_x0[r] && dx <= r_x1[r]
          && dy >= r_y0[r] && dy <= r_y1[r]) begin
        found = 1; p = r_own[r]; nx = n_adr[r_own[r]];
      end
    if (!found) e = 1;
  endtask

  task automatic lookup(input logic [4:0] dx, dy);
    @(negedge clk);
    in_valid = 1; in_dx = dx; in_dy = dy;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check_ref(input string req, input logic [4:0] dx, dy);
    logic [2:0] p; logic [9:0] nx; logic d, e;
    ref_look(dx, dy, p, nx, d, e);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " port"}, 32'(out_port), 32'(p));
    chk({req, " next"}, 32'(out_next), 32'(nx));
    chk({req, " direct"}, 32'(out_direct), 32'(d));
    chk({req, " err"}, 32'(out_err), 32'(e));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      r_en[i] = 0; r_x0[i] = 0; r_x1[i] = 0; r_y0[i] = 0; r_y1[i] = 0; r_own[i] = 0;
      n_en[i] = 0; n_adr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    lookup(5'd4, 5'd4);
    chk("R1 empty tables err", 32'(out_err), 32'd1);
    chk("R6 empty port", 32'(out_port), 32'd0);

    // Configuration
    wr_nbr(0, 1, {5'd4, 5'd4});
    wr_nbr(1, 1, {5'd20, 5'd4});
    wr_nbr(2, 1, {5'd20, 5'd20});
    wr_nbr(3, 1, {5'd4, 5'd20});
    wr_rgn(0, 1, 5'd0,  5'd9,  5'd0,  5'd9,  3'd0);
    wr_rgn(1, 1, 5'd10, 5'd31, 5'd0,  5'd15, 3'd1);
    wr_rgn(2, 1, 5'd8,  5'd30, 5'd12, 5'd31, 3'd2);
    wr_rgn(3, 1, 5'd0,  5'd7,  5'd10, 5'd31, 3'd3);
    wr_rgn(4, 1, 5'd5,  5'd15, 5'd5,  5'd15, 3'd2);
    wr_rgn(5, 0, 5'd0,  5'd31, 5'd0,  5'd31, 3'd5);  // disabled, R9

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      logic [4:0] dx, dy;
      dx = VEC[v][24:20]; dy = VEC[v][19:15];
      lookup(dx, dy);
      chk("R7 valid after accept", 32'(out_valid), 32'd1);
      chk("R2/R5 port", 32'(out_port), 32'(VEC[v][14:12]));
      chk("R5/R10 next", 32'(out_next), 32'(VEC[v][11:2]));
      chk("R2 direct", 32'(out_direct), 32'(VEC[v][1]));
      chk("R6 err", 32'(out_err), 32'(VEC[v][0]));
      check_ref("R3/R4 reference", dx, dy);
    end

    // R7: valid drops after result taken
    @(negedge clk);
    chk("R7 valid drops", 32'(out_valid), 32'd0);

    // R9: rewrite owner of r1, add neighbor 4
    wr_rgn(1, 1, 5'd10, 5'd31, 5'd0, 5'd15, 3'd3);
    lookup(5'd10, 5'd0);
    chk("R9 new owner port", 32'(out_port), 32'd3);
    chk("R9 new owner next", 32'(out_next), 32'd148);
    wr_nbr(4, 1, {5'd31, 5'd20});
    lookup(5'd31, 5'd20);
    chk("R9 new neighbor port", 32'(out_port), 32'd4);
    chk("R9 new neighbor direct", 32'(out_direct), 32'd1);
    check_ref("R9 reference", 5'd31, 5'd20);

    // R8: stall
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_dx = 5'd0; in_dy = 5'd0;
    @(negedge clk);
    in_dx = 5'd15; in_dy = 5'd16;  // second destination waits
    chk("R8 in_ready low", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 held valid", 32'(out_valid), 32'd1);
    chk("R8 held port", 32'(out_port), 32'd0);
    chk("R8 held next", 32'(out_next), 32'd132);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 second result port", 32'(out_port), 32'd2);
    chk("R8 second result next", 32'(out_next), 32'd660);
    @(negedge clk);
    chk("R7 idle", 32'(out_valid), 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule